// File: doc/BRIEF.md
# Coherent Word Access Bridge

This block sits between an 8-bit register bus and a 16-bit data path. It presents one 16-bit data word as two byte locations (low and high) plus a status location, and makes sure that software touching the word one byte at a time always sees, and hands over, a consistent 16-bit value. A read of either byte in word mode freezes both bytes until the partner byte is read. Writes are collected in a staging pair and passed to the transmit side as a single word, with a one-cycle load strobe, only once both halves are present.

A length-mode input selects byte mode or word mode. In byte mode the high location reads as zero and ignores writes, and a low-byte write alone forms the outgoing word. Any change of the length mode discards partial state. If the core reports a transfer in progress, it also raises an abort pulse. After a change, the block refuses to pass on new words until software has read the status location while the transmit-empty flag is set.

Top module: `wcoh_bridge`

## Requirements
- R1: In byte mode (`mode16`=0) a read of the high location (`bus_addr`=1) returns 0x00, and a write to it produces no load and leaves no staged byte behind.
- R2: In byte mode a write to the low location (`bus_addr`=0) forms the word {0x00, data} and loads it without waiting for any other access.
- R3: In word mode the first read of either data byte captures the live word; later reads return the captured bytes until the byte not yet read has been read, after which reads follow the live word again.
- R4: In word mode the outgoing word is loaded only when both bytes have been written, in either order; writing the same byte again before its partner replaces the staged value.
- R5: `tx_load` is high for exactly one cycle, beginning in the cycle after the completing write, with `tx_word` valid in that cycle; the same edge clears the transmit-empty flag (status bit 7).
- R6: A one-cycle `tx_drained` pulse sets the transmit-empty flag again.
- R7: A change of `mode16` while `core_busy` is high produces a one-cycle `xfer_abort` pulse in the next cycle; a change while `core_busy` is low produces none. Either change returns the transmit-empty flag to 1.
- R8: A change of `mode16` discards any partly staged write and any held read snapshot.
- R9: After a mode change, the block enters a locked state, shown as status bit 6. While locked, a completed write is discarded without a load. The lock is released when the status location (`bus_addr`=2) is read while the transmit-empty flag is 1.
- R10: After reset, the status location reads 0x80 (empty, unlocked), `tx_load` is 0 and `tx_word` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Location: 0 low byte, 1 high byte, 2 status, 3 reads zero |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while `bus_rd` is high |
| mode16 | input | 1 | Length mode: 1 word, 0 byte |
| core_busy | input | 1 | Core reports a transfer in progress |
| live_word | input | 16 | Current received word from the core |
| tx_drained | input | 1 | Pulse: core has taken the transmit word |
| tx_word | output | 16 | Word handed to the transmit side |
| tx_load | output | 1 | One-cycle strobe marking a new `tx_word` |
| xfer_abort | output | 1 | One-cycle pulse aborting the core's transfer |

## Verification
On every cycle, the assertions check the shape of the load strobe and its effect on the empty flag. They also check that no load occurs while locked, that the high byte is zero for a byte-mode load, that a byte-mode high read returns zero, and that every mode change clears the staging, snapshot and empty-flag state and raises the abort when required. Only the bench scenarios show the data itself. These include words assembled in both write orders, overwritten staged bytes, snapshot values held against a changing live word, and the release of the lock after a full status-read-then-write sequence.

// File: rtl/wcoh_pkg.sv
package wcoh_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        LOC_LO   = 2'd0,
        LOC_HI   = 2'd1,
        LOC_STAT = 2'd2,
        LOC_NONE = 2'd3
    } loc_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } word_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } pair_flags_t;

    // Status layout: bit 7 empty flag, bit 6 lock, rest zero.
    function automatic logic [BYTE_W-1:0] status_byte(input logic txe, input logic lock);
        return {txe, lock, {(BYTE_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/wcoh_rd_snap.sv
module wcoh_rd_snap
    import wcoh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              mode16,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  word_t             live,
    output logic [BYTE_W-1:0] val_lo,
    output logic [BYTE_W-1:0] val_hi,
    output logic              pend
);

    word_t snap_q;
    logic  pend_q;
    logic  opened_hi_q;

    always_comb begin
        if (!mode16) begin
            val_hi = '0;
            val_lo = live.lo;
        end else if (pend_q) begin
            val_hi = snap_q.hi;
            val_lo = snap_q.lo;
        end else begin
            val_hi = live.hi;
            val_lo = live.lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q      <= '0;
            pend_q      <= 1'b0;
            opened_hi_q <= 1'b0;
        end else if (clr) begin
            pend_q      <= 1'b0;
            opened_hi_q <= 1'b0;
        end else if (mode16) begin
            if (!pend_q && (rd_lo || rd_hi)) begin
                snap_q      <= live;
                pend_q      <= 1'b1;
                opened_hi_q <= rd_hi;
            end else if (pend_q && ((rd_hi && !opened_hi_q) || (rd_lo && opened_hi_q))) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/wcoh_wr_stage.sv
module wcoh_wr_stage
    import wcoh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              mode16,
    input  logic              allow,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic              fire,
    output pair_flags_t       have,
    output word_t             tx_word,
    output logic              tx_load
);

    word_t       stage_q;
    pair_flags_t have_q;
    pair_flags_t have_n;
    word_t       word_n;
    logic        complete;

    always_comb begin
        have_n.hi = have_q.hi | wr_hi;
        have_n.lo = have_q.lo | wr_lo;
        if (mode16) begin
            complete  = (wr_lo | wr_hi) & have_n.hi & have_n.lo;
            word_n.hi = wr_hi ? wdata : stage_q.hi;
            word_n.lo = wr_lo ? wdata : stage_q.lo;
        end else begin
            complete  = wr_lo;
            word_n.hi = '0;
            word_n.lo = wdata;
        end
        fire = complete & allow & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            have_q  <= '0;
            tx_word <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= fire;
            if (fire) begin
                tx_word <= word_n;
            end
            if (clr || complete) begin
                have_q <= '0;
            end else if (mode16) begin
                if (wr_hi) begin
                    stage_q.hi <= wdata;
                    have_q.hi  <= 1'b1;
                end
                if (wr_lo) begin
                    stage_q.lo <= wdata;
                    have_q.lo  <= 1'b1;
                end
            end
        end
    end

    assign have = have_q;

endmodule

// File: rtl/wcoh_ctl.sv
module wcoh_ctl (
    input  logic clk,
    input  logic rst,
    input  logic mode16,
    input  logic core_busy,
    input  logic stat_rd,
    input  logic fire,
    input  logic tx_drained,
    output logic mode_chg,
    output logic txe,
    output logic lock,
    output logic abort
);

    logic mode_q;

    assign mode_chg = (mode16 != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode16;
            txe    <= 1'b1;
            lock   <= 1'b0;
            abort  <= 1'b0;
        end else begin
            mode_q <= mode16;
            abort  <= mode_chg & core_busy;
            if (mode_chg) begin
                txe  <= 1'b1;
                lock <= 1'b1;
            end else begin
                if (fire) begin
                    txe <= 1'b0;
                end else if (tx_drained) begin
                    txe <= 1'b1;
                end
                if (stat_rd && txe) begin
                    lock <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wcoh_bridge.sv
module wcoh_bridge
    import wcoh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              mode16,
    input  logic              core_busy,
    input  logic [WORD_W-1:0] live_word,
    input  logic              tx_drained,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_load,
    output logic              xfer_abort
);

    loc_e              loc;
    logic              mode_chg;
    logic              rd_lo, rd_hi, wr_lo, wr_hi, stat_rd;
    logic              fire, txe, lock;
    logic              pend;
    pair_flags_t       have;
    logic [BYTE_W-1:0] val_lo, val_hi;
    word_t             word_out;

    assign loc     = loc_e'(bus_addr);
    assign rd_lo   = bus_rd & (loc == LOC_LO) & ~mode_chg;
    assign rd_hi   = bus_rd & (loc == LOC_HI) & ~mode_chg;
    assign stat_rd = bus_rd & (loc == LOC_STAT) & ~mode_chg;
    assign wr_lo   = bus_wr & (loc == LOC_LO) & ~mode_chg;
    assign wr_hi   = bus_wr & (loc == LOC_HI) & ~mode_chg & mode16;

    wcoh_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .mode16     (mode16),
        .core_busy  (core_busy),
        .stat_rd    (stat_rd),
        .fire       (fire),
        .tx_drained (tx_drained),
        .mode_chg   (mode_chg),
        .txe        (txe),
        .lock       (lock),
        .abort      (xfer_abort)
    );

    wcoh_rd_snap u_snap (
        .clk    (clk),
        .rst    (rst),
        .clr    (mode_chg),
        .mode16 (mode16),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .live   (word_t'(live_word)),
        .val_lo (val_lo),
        .val_hi (val_hi),
        .pend   (pend)
    );

    wcoh_wr_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .clr     (mode_chg),
        .mode16  (mode16),
        .allow   (~lock),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .fire    (fire),
        .have    (have),
        .tx_word (word_out),
        .tx_load (tx_load)
    );

    assign tx_word = word_out;

    always_comb begin
        unique case (loc)
            LOC_LO:   bus_rdata = val_lo;
            LOC_HI:   bus_rdata = val_hi;
            LOC_STAT: bus_rdata = status_byte(txe, lock);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wcoh_chk.sv
module wcoh_chk
    import wcoh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              mode16,
    input logic              core_busy,
    input logic              mode_chg,
    input logic              tx_load,
    input logic [WORD_W-1:0] tx_word,
    input logic              xfer_abort,
    input logic              txe,
    input logic              lock,
    input logic              pend,
    input pair_flags_t       have
);

    // R5
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    // R5
    load_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> !txe);

    // R9
    no_load_locked_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> !$past(lock));

    // R2
    byte_mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !$past(mode16)) |-> (tx_word[WORD_W-1:BYTE_W] == '0));

    // R1
    hi_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && !mode16) |-> (bus_rdata == '0));

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (xfer_abort == $past(core_busy)) && txe && lock);

    // R7
    abort_single_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |=> !xfer_abort);

    // R8
    mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !pend && (have == '0));

endmodule

bind wcoh_bridge wcoh_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .mode16     (mode16),
    .core_busy  (core_busy),
    .mode_chg   (mode_chg),
    .tx_load    (tx_load),
    .tx_word    (tx_word),
    .xfer_abort (xfer_abort),
    .txe        (txe),
    .lock       (lock),
    .pend       (pend),
    .have       (have)
);

// File: tb/sim_wcoh_bridge.sv
`timescale 1ns/1ps
module sim_wcoh_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        mode16 = 1'b1;
    logic        core_busy = 1'b0;
    logic [15:0] live_word = 16'h0000;
    logic        tx_drained = 1'b0;
    logic [15:0] tx_word;
    logic        tx_load;
    logic        xfer_abort;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    wcoh_bridge u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode16(mode16),
        .core_busy(core_busy), .live_word(live_word), .tx_drained(tx_drained),
        .tx_word(tx_word), .tx_load(tx_load), .xfer_abort(xfer_abort)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: every load pops one expected word.
    always @(negedge clk) begin
        if (!rst && tx_load) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected load", tx_word, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(tx_word == e, t, tx_word, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit load,
                      input logic [15:0] w, input string tag);
        @(negedge clk);
        if (load) begin
            exp_q.push_back(w);
            tag_q.push_back(tag);
        end
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!load) chk(tx_load == 1'b0, tag, tx_load, 0);
        else       chk(tx_load == 1'b1, tag, tx_load, 1);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata == e, tag, bus_rdata, e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_mode(input logic m, input logic busy, input string tag);
        @(negedge clk);
        mode16 = m; core_busy = busy;
        @(negedge clk);
        chk(xfer_abort == busy, tag, xfer_abort, busy);
        core_busy = 1'b0;
        @(negedge clk);
        chk(xfer_abort == 1'b0, tag, xfer_abort, 0);
    endtask

    task automatic drain();
        @(negedge clk);
        tx_drained = 1'b1;
        @(negedge clk);
        tx_drained = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_load == 1'b0, "R10 load", tx_load, 0);
        chk(tx_word == 16'h0000, "R10 word", tx_word, 0);
        rd(2'd2, 8'h80, "R10 status");

        // Word mode writes, both orders, overwrite
        wr(2'd0, 8'h5A, 1'b0, 16'h0, "R4 lo only");
        wr(2'd1, 8'hA5, 1'b1, 16'hA55A, "R4 lo then hi");
        rd(2'd2, 8'h00, "R5 empty cleared");
        drain();
        rd(2'd2, 8'h80, "R6 empty set");
        wr(2'd1, 8'h11, 1'b0, 16'h0, "R4 hi only");
        wr(2'd1, 8'h22, 1'b0, 16'h0, "R4 hi rewrite");
        wr(2'd0, 8'h33, 1'b1, 16'h2233, "R4 hi then lo");
        wr(2'd0, 8'h44, 1'b0, 16'h0, "R4 lo only");
        wr(2'd0, 8'h55, 1'b0, 16'h0, "R4 lo rewrite");
        wr(2'd1, 8'h66, 1'b1, 16'h6655, "R4 overwrite value");
        drain();

        // Snapshot reads
        live_word = 16'h1234;
        rd(2'd1, 8'h12, "R3 first hi");
        live_word = 16'hABCD;
        rd(2'd0, 8'h34, "R3 held lo");
        rd(2'd0, 8'hCD, "R3 fresh lo");
        live_word = 16'h5678;
        rd(2'd1, 8'hAB, "R3 held hi");
        rd(2'd1, 8'h56, "R3 fresh hi");
        rd(2'd0, 8'h78, "R3 close");

        // Snapshot pending across mode change, abort while busy
        live_word = 16'h1234;
        rd(2'd1, 8'h12, "R8 open snapshot");
        live_word = 16'hABCD;
        set_mode(1'b0, 1'b1, "R7 abort busy");
        rd(2'd2, 8'hC0, "R9 locked status");
        rd(2'd2, 8'h80, "R9 unlocked");

        // Byte mode
        rd(2'd1, 8'h00, "R1 hi reads zero");
        rd(2'd0, 8'hCD, "R2 lo live");
        wr(2'd1, 8'h99, 1'b0, 16'h0, "R1 hi write ignored");
        wr(2'd0, 8'h77, 1'b1, 16'h0077, "R2 lo commits");
        rd(2'd2, 8'h00, "R5 empty cleared byte mode");
        drain();

        // Back to word mode, not busy; snapshot gone; lock blocks commit
        set_mode(1'b1, 1'b0, "R7 no abort idle");
        rd(2'd0, 8'hCD, "R8 snapshot discarded");
        rd(2'd1, 8'hAB, "R3 close after change");
        wr(2'd1, 8'h11, 1'b0, 16'h0, "R9 hi while locked");
        wr(2'd0, 8'h22, 1'b0, 16'h0, "R9 discard while locked");
        rd(2'd2, 8'hC0, "R9 still locked");
        rd(2'd2, 8'h80, "R9 released");
        wr(2'd0, 8'h33, 1'b0, 16'h0, "R9 discarded stage empty");
        wr(2'd1, 8'h44, 1'b1, 16'h4433, "R9 commit after release");
        drain();

        // Staged byte dropped by mode change
        wr(2'd1, 8'h55, 1'b0, 16'h0, "R8 stage hi");
        set_mode(1'b0, 1'b0, "R7 no abort");
        rd(2'd2, 8'hC0, "R9 lock after change");
        set_mode(1'b1, 1'b1, "R7 abort busy again");
        rd(2'd2, 8'hC0, "R9 lock again");
        wr(2'd0, 8'h66, 1'b0, 16'h0, "R8 stage cleared");
        wr(2'd1, 8'h77, 1'b1, 16'h7766, "R8 fresh pair");
        rd(2'd2, 8'h00, "R5 empty cleared");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 missing load", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule